// File: doc/BRIEF.md
# Indirect Command/Data Register Port

This block sits on a 16-bit processor bus with a single address line. That line picks either the command port or the data port. Software first writes an 8-bit code to the command port. The low seven bits of the code pick an internal register, and the top bit says whether the following data phases store into that register or fetch from it. Data phases on the data port then move values in or out.

Behind the port are the following:

- a 16-bit configuration register;
- a 32-bit control register, which is moved in two halves;
- a 16-bit byte-count register;
- a fixed identification word;
- a reset trigger that works only through a key value;
- a streaming port into a 4-kbyte word RAM.

The streaming port moves one word per data phase. The number of words it moves is the byte count divided by two. Each new command restarts it at word zero.

Top module: `cmd_reg_port`

## Requirements
- R1: A command-port write (`bus_sel_cmd`=1, `bus_wr`=1) latches `bus_wdata[7:0]` as the current code. Bits [6:0] are the register index. Bit 7 = 1 lets data-port writes store. Bit 7 = 0 makes data-port writes have no effect.
- R2: The store code and the fetch code of a register differ only in bit 7. A value stored under code 0xA0 reads back under code 0x20.
- R3: Index 0x20 is a 16-bit register. Each data phase moves the whole word, and repeated reads return the same value.
- R4: Index 0x02 is a 32-bit register that takes two data phases. Bits [15:0] move first and bits [31:16] second. A new command restarts at the low half.
- R5: Index 0x27 reads the identification word 0x6107, whose high byte is 0x61. Writes to it have no effect.
- R6: Writing 0x00F6 under code 0xA9 returns the registers at 0x20, 0x02 and 0x22 to zero and keeps the RAM contents. Any other value written there does nothing.
- R7: Index 0x40 streams RAM words. Any new command resets the word pointer to zero and loads the word budget with the byte count at 0x22 divided by two. Each counted data phase moves one word and advances the pointer by one.
- R8: Once the word budget is used up, stream writes are ignored and stream reads return 0x0000.
- R9: Indices other than 0x02, 0x20, 0x22, 0x27 and 0x40 read as 0x0000. Writes to them change nothing.
- R10: After reset, `bus_rdata` is 0x0000 and all registers read 0x0000.
- R11: Read data appears on `bus_rdata` after the clock edge that samples the read strobe. It holds until the next data-port read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel_cmd | input | 1 | 1 selects the command port, 0 the data port |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data; the code is in bits [7:0] |
| bus_rdata | output | 16 | Read data of the last data-port read |

## Verification
Command and data writes take effect at the edge that samples the strobe. Read data, whether it comes from a register or from the RAM, is valid one edge after the read strobe.

The bench drives each strobe at a falling edge and holds it for one full cycle. It then samples `bus_rdata` at the next falling edge, which is half a cycle after the edge that captured the read.

Write effects are therefore observed only through a later read, never in the same cycle as the write. The hold check idles several cycles after a read and compares `bus_rdata` again.

// File: rtl/cmdport_pkg.sv
// Shared indices and constants of the command/data register port.
// Assumes a 7-bit register index with bit 7 of the code selecting a store.
package cmdport_pkg;
    localparam int          CODE_W    = 8;
    localparam logic [6:0]  IDX_WIDE  = 7'h02;
    localparam logic [6:0]  IDX_CFG   = 7'h20;
    localparam logic [6:0]  IDX_XFER  = 7'h22;
    localparam logic [6:0]  IDX_ID    = 7'h27;
    localparam logic [6:0]  IDX_SRST  = 7'h29;
    localparam logic [6:0]  IDX_BUF   = 7'h40;
    localparam logic [15:0] SRST_KEY  = 16'h00F6;

    // Indices that return data on a data-port read.
    function automatic logic idx_readable(input logic [6:0] i);
        return (i == IDX_WIDE) || (i == IDX_CFG) || (i == IDX_XFER) ||
               (i == IDX_ID) || (i == IDX_BUF);
    endfunction
endpackage

// File: rtl/cmdport_decode.sv
// Command latch and data-phase sequencer.
// Holds the current code, the half-select of the wide register, and the
// RAM stream pointer and remaining word budget.
// Assumes a one-cycle strobe per bus access.
module cmdport_decode
    import cmdport_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_sel_cmd,
    input  logic [CODE_W-1:0] code_in,
    input  logic [DW-2:0] budget_in,
    output logic [6:0]    idx,
    output logic          is_wr,
    output logic          phase_hi,
    output logic          data_wr,
    output logic          data_rd,
    output logic          buf_live,
    output logic [AW-1:0] buf_ptr,
    output logic [DW-2:0] words_left
);
    logic [CODE_W-1:0] code_q;

    assign idx      = code_q[6:0];
    assign is_wr    = code_q[7];
    assign data_wr  = bus_wr & ~bus_sel_cmd;
    assign data_rd  = bus_rd & ~bus_sel_cmd;
    assign buf_live = (idx == IDX_BUF) && (words_left != '0);

    // Latch a new code and restart phases, or advance on data phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q     <= '0;
            phase_hi   <= 1'b0;
            buf_ptr    <= '0;
            words_left <= '0;
        end else if (bus_wr && bus_sel_cmd) begin
            code_q     <= code_in;
            phase_hi   <= 1'b0;
            buf_ptr    <= '0;
            words_left <= budget_in;
        end else begin
            if ((data_wr || data_rd) && idx == IDX_WIDE)
                phase_hi <= ~phase_hi;
            if ((data_rd || (data_wr && is_wr)) && buf_live) begin
                buf_ptr    <= buf_ptr + 1'b1;
                words_left <= words_left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmdport_regs.sv
// Register bank: 16-bit config, 32-bit control, byte count, fixed ID.
// The key write clears the bank.
// Read data is registered on a data-port read strobe.
module cmdport_regs
    import cmdport_pkg::*;
#(
    parameter int          DW       = 16,
    parameter logic [15:0] ID_VALUE = 16'h6107
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [6:0]    idx,
    input  logic          phase_hi,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] reg_q,
    output logic [DW-1:0] xfer_bytes
);
    logic [DW-1:0]   cfg_r;
    logic [2*DW-1:0] wide_r;
    logic [DW-1:0]   rd_val;
    logic            key_hit;

    assign key_hit = wr_en && (idx == IDX_SRST) && (wdata == SRST_KEY);

    // Store writes into the addressed register; reset or key clears all.
    always_ff @(posedge clk) begin
        if (!rst_n || key_hit) begin
            cfg_r      <= '0;
            wide_r     <= '0;
            xfer_bytes <= '0;
        end else if (wr_en) begin
            case (idx)
                IDX_CFG:  cfg_r <= wdata;
                IDX_XFER: xfer_bytes <= wdata;
                IDX_WIDE: begin
                    if (phase_hi) wide_r[2*DW-1:DW] <= wdata;
                    else          wide_r[DW-1:0]    <= wdata;
                end
                default: ;
            endcase
        end
    end

    // Select the value a data-port read returns.
    always_comb begin
        case (idx)
            IDX_CFG:  rd_val = cfg_r;
            IDX_XFER: rd_val = xfer_bytes;
            IDX_ID:   rd_val = ID_VALUE[DW-1:0];
            IDX_WIDE: rd_val = phase_hi ? wide_r[2*DW-1:DW] : wide_r[DW-1:0];
            default:  rd_val = '0;
        endcase
    end

    // Capture read data on each data-port read.
    always_ff @(posedge clk) begin
        if (!rst_n)     reg_q <= '0;
        else if (rd_en) reg_q <= rd_val;
    end
endmodule

// File: rtl/cmdport_ram.sv
// Single-port word RAM with synchronous write and registered read.
// No reset: contents survive resets by design.
module cmdport_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    logic [DW-1:0] mem [DEPTH];

    // Write on we, read into q on re.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) q <= mem[addr];
    end
endmodule

// File: rtl/cmd_reg_port.sv
// Top of the command/data register port.
// A command write selects a register. Data phases then store or fetch it,
// or stream words into or out of the RAM.
// Assumes single-cycle strobes and only one of bus_wr/bus_rd per cycle.
module cmd_reg_port #(
    parameter int          DW        = 16,
    parameter int          BUF_BYTES = 4096,
    parameter logic [15:0] ID_VALUE  = 16'h6107
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel_cmd,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata
);
    localparam int BUF_WORDS = BUF_BYTES / (DW / 8);
    localparam int AW        = $clog2(BUF_WORDS);

    logic [6:0]    cur_idx;
    logic          cur_is_wr, phase_hi, data_wr, data_rd, buf_live, buf_sel_q;
    logic [AW-1:0] buf_ptr;
    logic [DW-2:0] words_left;
    logic [DW-1:0] xfer_bytes, reg_q, ram_q;

    cmdport_decode #(.AW(AW), .DW(DW)) u_dec (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel_cmd(bus_sel_cmd), .code_in(bus_wdata[7:0]),
        .budget_in(xfer_bytes[DW-1:1]), .idx(cur_idx), .is_wr(cur_is_wr),
        .phase_hi(phase_hi), .data_wr(data_wr), .data_rd(data_rd),
        .buf_live(buf_live), .buf_ptr(buf_ptr), .words_left(words_left)
    );

    cmdport_regs #(.DW(DW), .ID_VALUE(ID_VALUE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(data_wr & cur_is_wr),
        .rd_en(data_rd), .idx(cur_idx), .phase_hi(phase_hi),
        .wdata(bus_wdata), .reg_q(reg_q), .xfer_bytes(xfer_bytes)
    );

    cmdport_ram #(.DW(DW), .DEPTH(BUF_WORDS)) u_ram (
        .clk(clk), .we(data_wr & cur_is_wr & buf_live),
        .re(data_rd & buf_live), .addr(buf_ptr), .wdata(bus_wdata), .q(ram_q)
    );

    // Remember whether the last read came from the RAM stream.
    always_ff @(posedge clk) begin
        if (!rst_n)       buf_sel_q <= 1'b0;
        else if (data_rd) buf_sel_q <= buf_live;
    end

    assign bus_rdata = buf_sel_q ? ram_q : reg_q;
endmodule

// File: rtl/cmdport_chk.sv
// Assertion checker bound to cmd_reg_port.
module cmdport_chk
    import cmdport_pkg::*;
#(
    parameter int          DW       = 16,
    parameter logic [15:0] ID_VALUE = 16'h6107
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel_cmd,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic [6:0]    cur_idx,
    input logic          cur_is_wr,
    input logic [DW-2:0] words_left,
    input logic [DW-1:0] xfer_bytes
);
    AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_sel_cmd && cur_idx == IDX_ID) |=> bus_rdata == ID_VALUE[DW-1:0]); // R5
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_sel_cmd && !idx_readable(cur_idx)) |=> bus_rdata == '0); // R9
    AST_BUDGET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel_cmd) |=> words_left == $past(xfer_bytes[DW-1:1])); // R7
    AST_BUDGET_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_sel_cmd) |=> words_left <= $past(words_left)); // R8
    AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel_cmd && cur_is_wr && cur_idx == IDX_SRST && bus_wdata == SRST_KEY)
        |=> xfer_bytes == '0); // R6
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !bus_sel_cmd) |=> $stable(bus_rdata)); // R11
endmodule

bind cmd_reg_port cmdport_chk #(.DW(DW), .ID_VALUE(ID_VALUE)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel_cmd(bus_sel_cmd), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cur_idx(cur_idx), .cur_is_wr(cur_is_wr), .words_left(words_left),
    .xfer_bytes(xfer_bytes)
);

// File: tb/cmd_reg_port_test.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module cmd_reg_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel_cmd = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    cmd_reg_port uut (
        .clk(clk), .rst_n(rst_n), .bus_sel_cmd(bus_sel_cmd), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Entry: {op, req, value}. op 0 = command write, 1 = data write,
    // 2 = data read with expected value.
    localparam int NV = 56;
    localparam logic [21:0] VEC [NV] = '{
        {2'd0, 4'd1,  16'h00A0}, {2'd1, 4'd1,  16'h1234},  // R1 store cfg
        {2'd0, 4'd2,  16'h0020}, {2'd2, 4'd2,  16'h1234},  // R2 fetch code
        {2'd2, 4'd3,  16'h1234},                           // R3 repeat read
        {2'd1, 4'd1,  16'h5555}, {2'd2, 4'd1,  16'h1234},  // R1 write under fetch code ignored
        {2'd0, 4'd4,  16'h0082}, {2'd1, 4'd4,  16'hBEEF},  // R4 low half
        {2'd1, 4'd4,  16'hCAFE},                           // R4 high half
        {2'd0, 4'd4,  16'h0002}, {2'd2, 4'd4,  16'hBEEF},
        {2'd2, 4'd4,  16'hCAFE},
        {2'd0, 4'd5,  16'h0027}, {2'd2, 4'd5,  16'h6107},  // R5 ID
        {2'd0, 4'd5,  16'h00A7}, {2'd1, 4'd5,  16'h0000},
        {2'd0, 4'd5,  16'h0027}, {2'd2, 4'd5,  16'h6107},  // R5 write ignored
        {2'd0, 4'd9,  16'h0095}, {2'd1, 4'd9,  16'hFFFF},  // R9 undefined
        {2'd0, 4'd9,  16'h0015}, {2'd2, 4'd9,  16'h0000},
        {2'd0, 4'd7,  16'h00A2}, {2'd1, 4'd7,  16'h0006},  // R7 3 words
        {2'd0, 4'd7,  16'h00C0}, {2'd1, 4'd7,  16'h1111},
        {2'd1, 4'd7,  16'h2222}, {2'd1, 4'd7,  16'h3333},
        {2'd1, 4'd8,  16'h4444},                           // R8 beyond budget
        {2'd0, 4'd7,  16'h0040}, {2'd2, 4'd7,  16'h1111},
        {2'd2, 4'd7,  16'h2222}, {2'd2, 4'd7,  16'h3333},
        {2'd2, 4'd8,  16'h0000},                           // R8 exhausted
        {2'd0, 4'd7,  16'h0040}, {2'd2, 4'd7,  16'h1111},  // R7 pointer restart
        {2'd0, 4'd7,  16'h0022}, {2'd2, 4'd7,  16'h0006},
        {2'd0, 4'd6,  16'h00A9}, {2'd1, 4'd6,  16'h0055},  // R6 wrong key
        {2'd0, 4'd6,  16'h0020}, {2'd2, 4'd6,  16'h1234},
        {2'd0, 4'd6,  16'h00A9}, {2'd1, 4'd6,  16'h00F6},  // R6 key
        {2'd0, 4'd6,  16'h0020}, {2'd2, 4'd6,  16'h0000},
        {2'd0, 4'd6,  16'h0002}, {2'd2, 4'd6,  16'h0000},
        {2'd2, 4'd6,  16'h0000},
        {2'd0, 4'd6,  16'h0022}, {2'd2, 4'd6,  16'h0000},
        {2'd0, 4'd6,  16'h00A2}, {2'd1, 4'd6,  16'h0002},
        {2'd0, 4'd6,  16'h0040}, {2'd2, 4'd6,  16'h1111}   // R6 RAM kept
    };

    task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    // One-cycle access: drive after a falling edge, release at the next.
    task automatic access(input logic sel, input logic wr, input logic [15:0] d);
        bus_sel_cmd = sel; bus_wr = wr; bus_rd = ~wr; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic rd_check(input int req, input logic [15:0] exp);
        access(1'b0, 1'b0, 16'h0);
        check(req, bus_rdata, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check(10, bus_rdata, 16'h0000);                    // R10 output after reset
        foreach (VEC[i]) begin
            case (VEC[i][21:20])
                2'd0:    access(1'b1, 1'b1, VEC[i][15:0]);
                2'd1:    access(1'b0, 1'b1, VEC[i][15:0]);
                default: rd_check(int'(VEC[i][19:16]), VEC[i][15:0]);
            endcase
        end
        // R11: read data holds across idle cycles and a command write.
        access(1'b1, 1'b1, 16'h0027);
        rd_check(11, 16'h6107);
        repeat (3) @(negedge clk);
        check(11, bus_rdata, 16'h6107);
        access(1'b1, 1'b1, 16'h0020);
        check(11, bus_rdata, 16'h6107);
        // R10: a hardware reset clears registers and the read data.
        access(1'b1, 1'b1, 16'h00A0);
        access(1'b0, 1'b1, 16'h7777);
        do_reset();
        check(10, bus_rdata, 16'h0000);
        access(1'b1, 1'b1, 16'h0020);
        rd_check(10, 16'h0000);
        access(1'b1, 1'b1, 16'h0022);
        rd_check(10, 16'h0000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule